// File: doc/BRIEF.md
# Nibble-Written CHR Bank Mapper

This block divides the 8 KB pattern window of the picture processor (addresses 0x0000 to 0x1FFF) into eight 1 KB slots. Each slot has its own 8-bit bank number. The block joins that bank number to the low ten bits of the picture address to form a physical character-ROM address. The translation is combinational, so a fetch sees the current bank in the same cycle that the address is presented.

Software on the CPU never writes a whole bank number in one store. Each number is built from two separate 4-bit stores, one for the low half and one for the high half. A store changes only the half it targets and uses only data bits [3:0].

The four CPU pages 0xB000, 0xC000, 0xD000 and 0xE000 each hold two slots. Inside each page the offsets respond at two aliased positions. This lets a board connect the low CPU address lines to the register select in either of two ways and still work.

Top module: `chr_slot_mapper`

## Requirements
- R1: After a synchronous reset all eight bank numbers are zero, so `chr_addr` equals `{8'h00, ppu_addr[9:0]}` for every in-window picture address.
- R2: A write with `cpu_addr & 16'hF00F` equal to page|0x0 replaces bits [3:0] of the page's even slot with `cpu_data[3:0]`.
- R3: A write at page|0x2 or page|0x8 replaces bits [7:4] of the page's even slot with `cpu_data[3:0]`. The two offsets act identically.
- R4: A write at page|0x1 or page|0x4 replaces bits [3:0] of the page's odd slot with `cpu_data[3:0]`.
- R5: A write at page|0x3 or page|0xC replaces bits [7:4] of the page's odd slot with `cpu_data[3:0]`.
- R6: A nibble write leaves the other half of the same bank number unchanged and ignores `cpu_data[7:4]`. No other slot changes.
- R7: Page 0xB000 selects slots 0 and 1, page 0xC000 slots 2 and 3, page 0xD000 slots 4 and 5, and page 0xE000 slots 6 and 7. At most one slot is written per cycle.
- R8: `chr_addr = {bank[ppu_addr[12:10]], ppu_addr[9:0]}`. It follows `ppu_addr` with no clock, and a write becomes visible after the clock edge that takes it.
- R9: The bank numbers do not change in any of these cases:
  - `cpu_wr_en` is low;
  - `cpu_addr[11:4]` is non-zero;
  - the page is outside 0xB000 to 0xE000;
  - the low offset is 0x5, 0x6, 0x7, 0x9, 0xA, 0xB, 0xD, 0xE or 0xF.
- R10: `chr_sel` is 1 when `ppu_addr < 14'h2000` and 0 when `ppu_addr >= 14'h2000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank registers |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data; only bits [3:0] are used |
| ppu_addr | input | 14 | Picture processor fetch address |
| chr_addr | output | 18 | Physical character-ROM address |
| chr_sel | output | 1 | High while `ppu_addr` lies in the pattern window |

## Verification
The hardest case is proving that a nibble store preserved the other half of a bank number. The port only shows a whole bank number, and only for the slot the picture address currently selects. The stimulus therefore first builds each bank number from both halves, using every alias offset. It then rewrites only the low half and probes an address inside that slot, so that the untouched high half shows directly in `chr_addr[17:14]`. Writes that must be ignored are each followed by a probe of the slot they would have hit.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

    localparam int CPU_AW    = 16;
    localparam int DATA_W    = 8;
    localparam int NIB_W     = 4;
    localparam int BANK_W    = 2 * NIB_W;
    localparam int SLOT_CNT  = 8;
    localparam int SLOT_AW   = 10;
    localparam int PPU_AW    = 14;

    localparam int SLOT_IDX_W = $clog2(SLOT_CNT);
    localparam int PAIR_W     = SLOT_IDX_W - 1;
    localparam int WINDOW_AW  = SLOT_IDX_W + SLOT_AW;
    localparam int CHR_AW     = BANK_W + SLOT_AW;

    localparam logic [3:0] FIRST_PAGE = 4'hB;
    localparam logic [3:0] LAST_PAGE  = 4'(FIRST_PAGE + SLOT_CNT / 2 - 1);

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic                  hit;
        logic [SLOT_IDX_W-1:0] slot;
        half_e                 half;
        logic [NIB_W-1:0]      nib;
    } nib_wr_t;

    typedef struct packed {
        logic  hit;
        logic  odd;
        half_e half;
    } offset_dec_t;

    function automatic offset_dec_t decode_offset(input logic [3:0] off);
        offset_dec_t r;
        r = '{hit: 1'b1, odd: 1'b0, half: HALF_LO};
        case (off)
            4'h0:        begin r.odd = 1'b0; r.half = HALF_LO; end
            4'h2, 4'h8:  begin r.odd = 1'b0; r.half = HALF_HI; end
            4'h1, 4'h4:  begin r.odd = 1'b1; r.half = HALF_LO; end
            4'h3, 4'hC:  begin r.odd = 1'b1; r.half = HALF_HI; end
            default:     r.hit = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic page_in_range(input logic [3:0] page);
        return (page >= FIRST_PAGE) && (page <= LAST_PAGE);
    endfunction

endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
    import chr_map_pkg::*;
#(
    parameter int N_SLOTS = SLOT_CNT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CPU_AW-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output nib_wr_t              cmd,
    output logic [N_SLOTS-1:0]   slot_stb
);

    logic [3:0]        page;
    logic [3:0]        page_rel;
    logic              mid_zero;
    offset_dec_t       odec;

    always_comb begin
        page     = addr[CPU_AW-1 -: 4];
        page_rel = page - FIRST_PAGE;
        mid_zero = (addr[CPU_AW-5:4] == '0);
        odec     = decode_offset(addr[3:0]);

        cmd.hit  = wr_en && page_in_range(page) && mid_zero && odec.hit;
        cmd.slot = {page_rel[PAIR_W-1:0], odec.odd};
        cmd.half = odec.half;
        cmd.nib  = data[NIB_W-1:0];
    end

    generate
        for (genvar s = 0; s < N_SLOTS; s++) begin : g_stb
            assign slot_stb[s] = cmd.hit && (cmd.slot == SLOT_IDX_W'(s));
        end
    endgenerate

    AST_ONE_SLOT_PER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_stb)); // R7

    AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (slot_stb != '0) |-> wr_en); // R9

    AST_STROBE_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (slot_stb != '0) |-> (addr[CPU_AW-5:4] == '0)); // R9

endmodule

// File: rtl/chr_bank_slot.sv
module chr_bank_slot
    import chr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  half_e             half,
    input  logic [NIB_W-1:0]  nib,
    output logic [BANK_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (stb) begin
            if (half == HALF_HI) q[BANK_W-1:NIB_W] <= nib;
            else                 q[NIB_W-1:0]      <= nib;
        end
    end

    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (stb && half == HALF_LO) |=>
            (q[BANK_W-1:NIB_W] == $past(q[BANK_W-1:NIB_W])) &&
            (q[NIB_W-1:0] == $past(nib))); // R6

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (stb && half == HALF_HI) |=>
            (q[NIB_W-1:0] == $past(q[NIB_W-1:0])) &&
            (q[BANK_W-1:NIB_W] == $past(nib))); // R6

    AST_IDLE_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(q)); // R9

endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_map_pkg::*;
#(
    parameter int N_SLOTS = SLOT_CNT
) (
    input  logic                            clk,
    input  logic                            rst,
    input  nib_wr_t                         cmd,
    input  logic [N_SLOTS-1:0]              slot_stb,
    output logic [N_SLOTS-1:0][BANK_W-1:0]  banks
);

    generate
        for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
            chr_bank_slot u_slot (
                .clk  (clk),
                .rst  (rst),
                .stb  (slot_stb[s]),
                .half (cmd.half),
                .nib  (cmd.nib),
                .q    (banks[s])
            );
        end
    endgenerate

    AST_STROBE_MATCHES_CMD: assert property (@(posedge clk) disable iff (rst)
        (slot_stb != '0) |-> (cmd.hit && slot_stb[cmd.slot])); // R7

endmodule

// File: rtl/chr_addr_compose.sv
module chr_addr_compose
    import chr_map_pkg::*;
#(
    parameter int N_SLOTS = SLOT_CNT
) (
    input  logic [N_SLOTS-1:0][BANK_W-1:0] banks,
    input  logic [PPU_AW-1:0]              ppu_addr,
    output logic [CHR_AW-1:0]              chr_addr,
    output logic                           chr_sel
);

    logic [SLOT_IDX_W-1:0] idx;

    always_comb begin
        idx      = ppu_addr[SLOT_AW +: SLOT_IDX_W];
        chr_addr = {banks[idx], ppu_addr[SLOT_AW-1:0]};
        chr_sel  = (ppu_addr[PPU_AW-1:WINDOW_AW] == '0);
    end

endmodule

// File: rtl/chr_slot_mapper.sv
module chr_slot_mapper
    import chr_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_wr_en,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_data,
    input  logic [13:0]        ppu_addr,
    output logic [17:0]        chr_addr,
    output logic               chr_sel
);

    nib_wr_t                          cmd;
    logic [SLOT_CNT-1:0]              slot_stb;
    logic [SLOT_CNT-1:0][BANK_W-1:0]  banks;

    chr_wr_decode #(.N_SLOTS(SLOT_CNT)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cpu_wr_en),
        .addr     (cpu_addr),
        .data     (cpu_data),
        .cmd      (cmd),
        .slot_stb (slot_stb)
    );

    chr_bank_regs #(.N_SLOTS(SLOT_CNT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .slot_stb (slot_stb),
        .banks    (banks)
    );

    chr_addr_compose #(.N_SLOTS(SLOT_CNT)) u_compose (
        .banks    (banks),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr),
        .chr_sel  (chr_sel)
    );

endmodule

// File: tb/tb_chr_slot_mapper.sv
module tb_chr_slot_mapper;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_wr_en;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [13:0] ppu_addr;
    logic [17:0] chr_addr;
    logic        chr_sel;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    chr_slot_mapper dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr_en (cpu_wr_en),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .ppu_addr  (ppu_addr),
        .chr_addr  (chr_addr),
        .chr_sel   (chr_sel)
    );

    typedef struct packed {
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [13:0] probe;
        logic [17:0] exp_chr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{16'hB000, 8'h05, 14'h0123, 18'h01523}, // R2 slot0 lo
        '{16'hB002, 8'h0A, 14'h03FF, 18'h297FF}, // R3 slot0 hi alias 2
        '{16'hB008, 8'h03, 14'h0000, 18'h0D400}, // R3 slot0 hi alias 8
        '{16'hB001, 8'hF7, 14'h0400, 18'h01C00}, // R4 R6 slot1 lo, upper data ignored
        '{16'hB004, 8'h02, 14'h07FF, 18'h00BFF}, // R4 slot1 lo alias 4
        '{16'hB003, 8'h09, 14'h0400, 18'h24800}, // R5 slot1 hi alias 3
        '{16'hB00C, 8'h06, 14'h0401, 18'h18801}, // R5 slot1 hi alias C
        '{16'hC000, 8'h01, 14'h0800, 18'h00400}, // R7 slot2
        '{16'hC00C, 8'h0C, 14'h0C10, 18'h30010}, // R7 slot3
        '{16'hD008, 8'h0E, 14'h1000, 18'h38000}, // R7 slot4
        '{16'hD004, 8'h0B, 14'h1555, 18'h02D55}, // R7 slot5
        '{16'hE002, 8'h04, 14'h1800, 18'h10000}, // R7 slot6
        '{16'hE001, 8'h0D, 14'h1FFF, 18'h037FF}, // R7 slot7
        '{16'hB000, 8'h0A, 14'h0000, 18'h0E800}, // R6 lo rewrite keeps hi
        '{16'hB005, 8'h0F, 14'h0400, 18'h18800}, // R9 offset 5
        '{16'hB010, 8'h0F, 14'h0000, 18'h0E800}, // R9 bits 11:4 set
        '{16'hA000, 8'h0F, 14'h0000, 18'h0E800}, // R9 page A
        '{16'hF001, 8'h0F, 14'h1C00, 18'h03400}, // R9 page F
        '{16'hB00F, 8'h07, 14'h0400, 18'h18800}  // R9 offset F
    };

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        cpu_addr  = a;
        cpu_data  = d;
        cpu_wr_en = en;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic probe(input logic [13:0] p);
        ppu_addr = p;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        cpu_wr_en = 1'b0;
        cpu_addr  = '0;
        cpu_data  = '0;
        ppu_addr  = '0;
        do_reset();

        // R1 reset state
        probe(14'h0000); check("R1", chr_addr, 18'h00000);
        probe(14'h1FFF); check("R1", chr_addr, 18'h003FF);
        probe(14'h0ABC); check("R1", chr_addr, 18'h002BC);

        // R10 window select
        probe(14'h1FFF); check("R10", {17'd0, chr_sel}, 18'd1);
        probe(14'h2000); check("R10", {17'd0, chr_sel}, 18'd0);
        probe(14'h3FFF); check("R10", {17'd0, chr_sel}, 18'd0);
        probe(14'h0000); check("R10", {17'd0, chr_sel}, 18'd1);

        // R9 write strobe low
        cpu_write(16'hB000, 8'h0F, 1'b0);
        probe(14'h0000); check("R9", chr_addr, 18'h00000);

        for (int i = 0; i < NV; i++) begin
            cpu_write(VECS[i].waddr, VECS[i].wdata, 1'b1);
            probe(VECS[i].probe);
            check($sformatf("R2-R9 vec%0d", i), chr_addr, VECS[i].exp_chr);
        end

        // R8 combinational follow of ppu_addr without a clock edge
        @(negedge clk);
        probe(14'h0400); check("R8", chr_addr, 18'h18800);
        probe(14'h1000); check("R8", chr_addr, 18'h38000);
        probe(14'h0C01); check("R8", chr_addr, 18'h30001);

        // R8 write is visible only after the taking edge
        @(negedge clk);
        ppu_addr  = 14'h1800;
        cpu_addr  = 16'hE000;
        cpu_data  = 8'h07;
        cpu_wr_en = 1'b1;
        #1; check("R8 before edge", chr_addr, 18'h10000);
        @(negedge clk);
        cpu_wr_en = 1'b0;
        #1; check("R8 after edge", chr_addr, 18'h11C00);

        // R1 reset clears again
        do_reset();
        probe(14'h0400); check("R1 re-reset", chr_addr, 18'h00000);
        probe(14'h1C05); check("R1 re-reset", chr_addr, 18'h00005);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule